// File: doc/BRIEF.md
# Dual-Synthesizer Serial Control Interface

This block is the programming front end of a two-channel frequency synthesizer with an RF channel and an IF channel. A host writes 24-bit words over a three-wire serial link made of a serial clock, a data line and an active-low load enable. The two lowest bits of each word pick one of four latches: RF reference, RF feedback, IF reference or IF feedback. The rest of the word is stored in that latch. The latches feed the parallel controls of the divider and charge-pump hardware, which sits outside this block.

All three serial lines are synchronized into the system clock domain. Bits are shifted MSB first on rising serial-clock edges while load enable is low. The shifted word is committed on the rising edge of load enable. The parallel outputs are registered, so the downstream counters never see a partly shifted value. Each feedback latch has a fastlock bit. While that bit is set, the channel's effective charge-pump code is forced to its maximum and the channel's damping-switch output is asserted.

Top module: `synth_ctrl_if`

## Requirements
- R1: After reset every divider value, charge-pump code and the mux select read zero, both fastlock outputs are low, and both power-down outputs are high.
- R2: A word is 24 bits, shifted MSB first. Bits 1:0 select the latch (0 = RF reference, 1 = RF feedback, 2 = IF reference, 3 = IF feedback). A commit changes only the outputs that come from the selected latch.
- R3: A reference latch holds the divider value in bits 15:2, a channel enable in bit 16 (the power-down output is its inverse) and the charge-pump code in bits 19:17.
- R4: A feedback latch holds the A count in bits 7:2 and the B count in bits 19:8.
- R5: Bit 20 of a feedback latch is the fastlock enable. While it is 1, the channel's charge-pump output is 7 and its fastlock output is high. Clearing it restores the programmed code and lowers the fastlock output.
- R6: The mux select output is {IF reference bits 21:20, RF reference bits 21:20}.
- R7: Serial clock edges seen while load enable is high do not shift the register.
- R8: A word shorter than 24 bits is still committed. Its k bits land in the low k positions, and the previous register contents move up by k.
- R9: The parallel outputs change only as a result of a load-enable rising edge, never while bits are being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdata | input | 1 | Serial data, MSB first |
| sload | input | 1 | Load enable, active low; its rising edge commits the word |
| rf_ref_div | output | 14 | RF reference divider value |
| rf_a_cnt | output | 6 | RF A count |
| rf_b_cnt | output | 12 | RF B count |
| rf_cp_code | output | 3 | RF effective charge-pump code |
| rf_pd | output | 1 | RF power-down |
| rf_fastlock | output | 1 | RF damping-switch control |
| if_ref_div | output | 14 | IF reference divider value |
| if_a_cnt | output | 6 | IF A count |
| if_b_cnt | output | 12 | IF B count |
| if_cp_code | output | 3 | IF effective charge-pump code |
| if_pd | output | 1 | IF power-down |
| if_fastlock | output | 1 | IF damping-switch control |
| mux_sel | output | 4 | Output-mux select code |

## Verification
The checks assume that the serial lines are slow compared with the system clock. Every level of sclk, sdata and sload must hold for more system cycles than the synchronizer depth plus one. Data must be settled before its serial-clock rise. No load-enable rise may share a synchronized cycle with a serial-clock rise. The stimulus holds each serial level for four system clocks, changes data only while the serial clock is low, and waits a half bit between the last bit and the load-enable rise.

// File: rtl/sci_pkg.sv
package sci_pkg;
  localparam int WORD_W    = 24;
  localparam int SEL_W     = 2;
  localparam int NUM_CHANS = 2;
  localparam int NUM_LAT   = 2 * NUM_CHANS;
  localparam int REF_W     = 14;
  localparam int A_W       = 6;
  localparam int B_W       = 12;
  localparam int CP_W      = 3;
  localparam int MUX_PER_R = 2;
  localparam int MUX_W     = MUX_PER_R * NUM_CHANS;

  // payload starts above the select bits
  localparam int PAY_LSB   = SEL_W;
  localparam int R_PAY_W   = REF_W + 1 + CP_W + MUX_PER_R;
  localparam int N_PAY_W   = A_W + B_W + 1;

  // reference payload layout
  localparam int R_REF_LSB = 0;
  localparam int R_EN_BIT  = R_REF_LSB + REF_W;
  localparam int R_CP_LSB  = R_EN_BIT + 1;
  localparam int R_MUX_LSB = R_CP_LSB + CP_W;

  // feedback payload layout
  localparam int N_A_LSB   = 0;
  localparam int N_B_LSB   = N_A_LSB + A_W;
  localparam int N_FL_BIT  = N_B_LSB + B_W;

  localparam logic [CP_W-1:0] CP_MAX = '1;

  typedef enum logic [SEL_W-1:0] {
    SEL_RF_REF = 2'd0,
    SEL_RF_FB  = 2'd1,
    SEL_IF_REF = 2'd2,
    SEL_IF_FB  = 2'd3
  } latch_sel_e;

  typedef struct packed {
    logic [REF_W-1:0] ref_div;
    logic [A_W-1:0]   a_cnt;
    logic [B_W-1:0]   b_cnt;
    logic [CP_W-1:0]  cp_code;
    logic             pd;
    logic             fastlock;
  } chan_out_t;
endpackage

// File: rtl/sci_sync.sv
module sci_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sci_shifter.sv
module sci_shifter #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              sdata_s,
  input  logic              load_s,
  output logic [WORD_W-1:0] shreg,
  output logic              commit
);
  logic sclk_q;
  logic load_q;
  logic shift_en;

  // shift only on a serial-clock rise while the load line is low
  assign shift_en = sclk_s & ~sclk_q & ~load_s;
  assign commit   = load_s & ~load_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      load_q <= 1'b1;
      shreg  <= '0;
    end else begin
      sclk_q <= sclk_s;
      load_q <= load_s;
      if (shift_en) shreg <= {shreg[WORD_W-2:0], sdata_s};
    end
  end
endmodule

// File: rtl/sci_latch_bank.sv
module sci_latch_bank
  import sci_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    commit,
  input  logic [SEL_W-1:0]        sel,
  input  logic [R_PAY_W-1:0]      pay,
  output logic [R_PAY_W-1:0]      r_lat [NUM_CHANS],
  output logic [N_PAY_W-1:0]      n_lat [NUM_CHANS],
  output logic [NUM_LAT-1:0]      wr_en
);
  for (genvar c = 0; c < NUM_CHANS; c++) begin : g_chan
    logic [R_PAY_W-1:0] r_q;
    logic [N_PAY_W-1:0] n_q;

    // even select codes address the reference latch, odd ones the feedback latch
    assign wr_en[2*c]   = commit && (sel == SEL_W'(2*c));
    assign wr_en[2*c+1] = commit && (sel == SEL_W'(2*c+1));

    always_ff @(posedge clk) begin
      if (rst) begin
        r_q <= '0;
        n_q <= '0;
      end else begin
        if (wr_en[2*c])   r_q <= pay;
        if (wr_en[2*c+1]) n_q <= pay[N_PAY_W-1:0];
      end
    end

    assign r_lat[c] = r_q;
    assign n_lat[c] = n_q;
  end
endmodule

// File: rtl/sci_decode.sv
module sci_decode
  import sci_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [R_PAY_W-1:0] r_lat [NUM_CHANS],
  input  logic [N_PAY_W-1:0] n_lat [NUM_CHANS],
  output chan_out_t          ch    [NUM_CHANS],
  output logic [MUX_W-1:0]   mux_sel
);
  logic [MUX_W-1:0] mux_d;

  for (genvar c = 0; c < NUM_CHANS; c++) begin : g_chan
    chan_out_t q;
    logic      fl;

    assign fl = n_lat[c][N_FL_BIT];
    assign mux_d[c*MUX_PER_R +: MUX_PER_R] = r_lat[c][R_MUX_LSB +: MUX_PER_R];

    always_ff @(posedge clk) begin
      if (rst) begin
        q    <= '0;
        q.pd <= 1'b1;
      end else begin
        q.ref_div  <= r_lat[c][R_REF_LSB +: REF_W];
        q.a_cnt    <= n_lat[c][N_A_LSB +: A_W];
        q.b_cnt    <= n_lat[c][N_B_LSB +: B_W];
        q.cp_code  <= fl ? CP_MAX : r_lat[c][R_CP_LSB +: CP_W];
        q.pd       <= ~r_lat[c][R_EN_BIT];
        q.fastlock <= fl;
      end
    end

    assign ch[c] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) mux_sel <= '0;
    else     mux_sel <= mux_d;
  end
endmodule

// File: rtl/synth_ctrl_if.sv
module synth_ctrl_if
  import sci_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk,
  input  logic             sdata,
  input  logic             sload,
  output logic [REF_W-1:0] rf_ref_div,
  output logic [A_W-1:0]   rf_a_cnt,
  output logic [B_W-1:0]   rf_b_cnt,
  output logic [CP_W-1:0]  rf_cp_code,
  output logic             rf_pd,
  output logic             rf_fastlock,
  output logic [REF_W-1:0] if_ref_div,
  output logic [A_W-1:0]   if_a_cnt,
  output logic [B_W-1:0]   if_b_cnt,
  output logic [CP_W-1:0]  if_cp_code,
  output logic             if_pd,
  output logic             if_fastlock,
  output logic [MUX_W-1:0] mux_sel
);
  logic               sclk_s, sdata_s, load_s;
  logic [WORD_W-1:0]  shreg;
  logic               commit;
  logic [NUM_LAT-1:0] wr_en;
  logic [R_PAY_W-1:0] r_lat [NUM_CHANS];
  logic [N_PAY_W-1:0] n_lat [NUM_CHANS];
  chan_out_t          ch    [NUM_CHANS];

  sci_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sload, sdata, sclk}),
    .q   ({load_s, sdata_s, sclk_s})
  );

  sci_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .sclk_s  (sclk_s),
    .sdata_s (sdata_s),
    .load_s  (load_s),
    .shreg   (shreg),
    .commit  (commit)
  );

  sci_latch_bank u_bank (
    .clk    (clk),
    .rst    (rst),
    .commit (commit),
    .sel    (shreg[SEL_W-1:0]),
    .pay    (shreg[PAY_LSB +: R_PAY_W]),
    .r_lat  (r_lat),
    .n_lat  (n_lat),
    .wr_en  (wr_en)
  );

  sci_decode u_dec (
    .clk     (clk),
    .rst     (rst),
    .r_lat   (r_lat),
    .n_lat   (n_lat),
    .ch      (ch),
    .mux_sel (mux_sel)
  );

  assign {rf_ref_div, rf_a_cnt, rf_b_cnt, rf_cp_code, rf_pd, rf_fastlock} = ch[0];
  assign {if_ref_div, if_a_cnt, if_b_cnt, if_cp_code, if_pd, if_fastlock} = ch[1];
endmodule

// File: rtl/sci_checker.sv
module sci_checker (
  input logic        clk,
  input logic        rst,
  input logic        load_s,
  input logic [23:0] shreg,
  input logic        commit,
  input logic [3:0]  wr_en,
  input logic [2:0]  rf_cp,
  input logic        rf_fl,
  input logic        rf_pd,
  input logic [2:0]  if_cp,
  input logic        if_fl,
  input logic        if_pd,
  input logic [77:0] outs
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (rf_pd && if_pd && !rf_fl && !if_fl && rf_cp == 3'd0 && if_cp == 3'd0));

  // R2
  one_latch_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(wr_en));

  // R5
  rf_fastlock_chk: assert property (@(posedge clk) disable iff (rst) rf_fl |-> rf_cp == 3'd7);

  // R5
  if_fastlock_chk: assert property (@(posedge clk) disable iff (rst) if_fl |-> if_cp == 3'd7);

  // R7
  idle_shift_chk: assert property (@(posedge clk) disable iff (rst) load_s |=> $stable(shreg));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(commit, 2) |-> $stable(outs));
endmodule

bind synth_ctrl_if sci_checker u_chk (
  .clk    (clk),
  .rst    (rst),
  .load_s (load_s),
  .shreg  (shreg),
  .commit (commit),
  .wr_en  (wr_en),
  .rf_cp  (rf_cp_code),
  .rf_fl  (rf_fastlock),
  .rf_pd  (rf_pd),
  .if_cp  (if_cp_code),
  .if_fl  (if_fastlock),
  .if_pd  (if_pd),
  .outs   ({rf_ref_div, rf_a_cnt, rf_b_cnt, rf_cp_code, rf_pd, rf_fastlock,
            if_ref_div, if_a_cnt, if_b_cnt, if_cp_code, if_pd, if_fastlock, mux_sel})
);

// File: tb/synth_ctrl_if_bench.sv
module synth_ctrl_if_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdata = 1'b0, sload = 1'b1;
  logic [13:0] rf_ref_div, if_ref_div;
  logic [5:0]  rf_a_cnt, if_a_cnt;
  logic [11:0] rf_b_cnt, if_b_cnt;
  logic [2:0]  rf_cp_code, if_cp_code;
  logic        rf_pd, if_pd, rf_fastlock, if_fastlock;
  logic [3:0]  mux_sel;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  logic [23:0] m_sh = '0;
  logic [23:0] m_lat [4];

  synth_ctrl_if u_synth_ctrl_if (
    .clk(clk), .rst(rst), .sclk(sclk), .sdata(sdata), .sload(sload),
    .rf_ref_div(rf_ref_div), .rf_a_cnt(rf_a_cnt), .rf_b_cnt(rf_b_cnt),
    .rf_cp_code(rf_cp_code), .rf_pd(rf_pd), .rf_fastlock(rf_fastlock),
    .if_ref_div(if_ref_div), .if_a_cnt(if_a_cnt), .if_b_cnt(if_b_cnt),
    .if_cp_code(if_cp_code), .if_pd(if_pd), .if_fastlock(if_fastlock),
    .mux_sel(mux_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [36:0] exp_chan(logic [23:0] r, logic [23:0] n);
    logic [2:0] cp;
    cp = n[20] ? 3'd7 : r[19:17];
    return {r[15:2], n[7:2], n[19:8], cp, ~r[16], n[20]};
  endfunction

  function automatic logic [77:0] exp_out();
    return {exp_chan(m_lat[0], m_lat[1]), exp_chan(m_lat[2], m_lat[3]),
            m_lat[2][21:20], m_lat[0][21:20]};
  endfunction

  function automatic logic [23:0] mk_ref(logic [13:0] dv, logic en, logic [2:0] cp,
                                         logic [1:0] mx, logic [1:0] sel);
    return {2'b00, mx, cp, en, dv, sel};
  endfunction

  function automatic logic [23:0] mk_fb(logic [5:0] a, logic [11:0] b, logic fl,
                                        logic [1:0] sel);
    return {3'b000, fl, b, a, sel};
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag);
    logic [77:0] act;
    act = {rf_ref_div, rf_a_cnt, rf_b_cnt, rf_cp_code, rf_pd, rf_fastlock,
           if_ref_div, if_a_cnt, if_b_cnt, if_cp_code, if_pd, if_fastlock, mux_sel};
    checks++;
    if (act !== exp_out()) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_out());
    end
  endtask

  task automatic shift_bit(logic b);
    sdata = b;
    wait_clk(HALF_BIT);
    sclk = 1'b1;
    if (!sload) m_sh = {m_sh[22:0], b};
    wait_clk(HALF_BIT);
    sclk = 1'b0;
  endtask

  task automatic load_low();
    sload = 1'b0;
    wait_clk(HALF_BIT);
  endtask

  task automatic load_high();
    wait_clk(HALF_BIT);
    sload = 1'b1;
    m_lat[m_sh[1:0]] = m_sh;
    wait_clk(10);
  endtask

  task automatic send_word(logic [23:0] w, int n);
    load_low();
    for (int i = n - 1; i >= 0; i--) shift_bit(w[i]);
    load_high();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) m_lat[i] = '0;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(10);
    check("R1 reset state");

    send_word(mk_ref(14'h2A5B, 1'b1, 3'd5, 2'b10, 2'd0), 24);
    check("R3 R2 RF reference latch");
    send_word(mk_fb(6'h2D, 12'hABC, 1'b0, 2'd1), 24);
    check("R4 R2 RF feedback latch");
    send_word(mk_ref(14'h0137, 1'b1, 3'd2, 2'b01, 2'd2), 24);
    check("R3 R6 IF reference latch");
    send_word(mk_fb(6'h3F, 12'h001, 1'b0, 2'd3), 24);
    check("R4 R2 IF feedback latch");
    send_word(mk_ref(14'h3FFF, 1'b0, 3'd1, 2'b11, 2'd2), 24);
    check("R6 R3 IF mux and power-down");

    send_word(mk_fb(6'h11, 12'h5A5, 1'b1, 2'd1), 24);
    check("R5 RF fastlock on");
    send_word(mk_fb(6'h11, 12'h5A5, 1'b0, 2'd1), 24);
    check("R5 RF fastlock off");
    send_word(mk_fb(6'h07, 12'hF0F, 1'b1, 2'd3), 24);
    check("R5 IF fastlock on");
    send_word(mk_fb(6'h07, 12'hF0F, 1'b0, 2'd3), 24);
    check("R5 IF fastlock off");

    // R9: halfway through a word the outputs still show the old values
    load_low();
    for (int i = 23; i >= 12; i--) shift_bit(i[0]);
    wait_clk(10);
    check("R9 outputs held mid-shift");
    for (int i = 11; i >= 0; i--) shift_bit(i == 1);
    load_high();
    check("R9 R2 word committed after load rise");

    // R7: clocks with load high must not move the register
    for (int i = 0; i < 6; i++) shift_bit(1'b1);
    send_word(24'h000A5, 10);
    check("R7 idle clocks ignored");

    // R8: short word merges with previous contents
    send_word(24'h00003, 6);
    check("R8 short word commit");

    for (int it = 0; it < 40; it++) begin
      logic [23:0] w;
      int len;
      w = 24'($urandom);
      len = ($urandom % 5 == 0) ? 8 + int'($urandom % 16) : 24;
      if ($urandom % 4 == 0) begin
        for (int k = 0; k < 3; k++) shift_bit(1'($urandom));
      end
      send_word(w, len);
      check(len == 24 ? "R2 R3 R4 R5 R6 random word" : "R8 R7 random short word");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule